// File: doc/BRIEF.md
# ADC Continuous Scan Channel Sequencer

This block holds the control word for a multi-channel analog-to-digital converter and runs the converter in continuous scan. Once the run bit is set, it asks the converter core for one conversion at a time. It waits for each done strobe and stores the returned code in a result register owned by that channel. It then moves straight on to the next channel of the group. After the last channel of the group it sets a sticky pass-complete flag and wraps back to the first channel. Scanning goes on for as long as the run bit stays at 1.

The run bit can be set in three ways: a write from software, a pulse from a timer, or a pulse from an external trigger pin. A group holds one to four consecutive channels. It begins at channel 0, or at channel 4 when the bank bit is set. Clearing the run bit stops the scan at once. A conversion that is still in flight is thrown away, and the next start begins again at the base of the group. The interrupt line is raised while the pass-complete flag is set and interrupts are enabled.

Top module: `adc_scan_seq`

## Requirements
- R1: The run bit (`start_bit`) becomes 1 on a clock edge where `trig_timer` or `trig_ext` is high, whatever a write in the same cycle carries. Otherwise, a write (`wr_en`) loads it from `wr_data[4]`, and with no write it holds its value. It resets to 0.
- R2: On the edge where the run bit goes from 0 to 1, `conv_start` rises for one cycle and `conv_ch` shows the group base.
- R3: The control word holds the channel count in `wr_data[1:0]` (values 0, 1, 2, 3 select 1, 2, 3, 4 channels), the bank bit in `wr_data[2]` and the interrupt enable in `wr_data[3]`. `conv_ch` equals the bank base (0, or 4 with the bank bit set) plus the position within the group.
- R4: When `conv_done` is high on an edge and the run bit stays 1, `conv_start` is high in the very next cycle and requests the next channel, with no idle cycle.
- R5: On the edge where a done is accepted, `conv_data` is stored in the `DATA_W`-bit slice of `res_flat` at position `conv_ch * DATA_W`. All other slices keep their values.
- R6: When the done of the last channel in the group is accepted, `end_flag` becomes 1. On the same edge, the request for the group base is issued.
- R7: When the run bit is cleared, including in the same cycle as a done, the pending result is discarded and no slice of `res_flat` changes. `conv_start` stays low until the next 0-to-1 change of the run bit, and that change restarts at the group base.
- R8: `end_flag` is sticky. A write with `wr_data[5]` = 0 clears it, and a write with `wr_data[5]` = 1 leaves it alone. A pass completing on the same edge as a clearing write leaves it at 1.
- R9: `irq` is high exactly when `end_flag` is 1 and the interrupt enable is 1.
- R10: A write that sets the run bit and changes count or bank in the same cycle starts the scan with the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 6 | Control word: count[1:0], bank[2], irq enable[3], run[4], flag keep[5] |
| trig_timer | input | 1 | Timer pulse that sets the run bit |
| trig_ext | input | 1 | External trigger pulse that sets the run bit |
| conv_start | output | 1 | One-cycle conversion request to the converter core |
| conv_ch | output | 3 | Channel number of the current request |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | DATA_W | Conversion code that comes with `conv_done` |
| res_flat | output | NUM_CH*DATA_W | Result registers, channel n at bits n*DATA_W |
| start_bit | output | 1 | Current run bit |
| end_flag | output | 1 | Sticky pass-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: the done of the last channel in a pass, which sets the flag, and a software write that clears that flag. The bench provokes this by holding a flag-clearing write ready and driving it onto exactly the cycle in which its converter model presents the final done. It then expects `end_flag` to read 1 after that edge. The same mechanism places a run-bit clear on a done cycle. There the bench expects every result slice to stay unchanged and no new request to appear.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int CFG_W   = 6;
    localparam int CNT_W   = 2;
    localparam int GRP_MAX = 2 ** CNT_W;

    // control word bit positions
    localparam int B_CNT_LO = 0;
    localparam int B_BANK   = 2;
    localparam int B_IE     = 3;
    localparam int B_RUN    = 4;
    localparam int B_KEEP   = 5;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bank;
        logic             ie;
    } scan_cfg_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_t;

    function automatic scan_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        scan_cfg_t c;
        c.cnt  = w[B_CNT_LO +: CNT_W];
        c.bank = w[B_BANK];
        c.ie   = w[B_IE];
        return c;
    endfunction

    function automatic logic idx_is_last(input logic [CNT_W-1:0] idx,
                                         input logic [CNT_W-1:0] cnt);
        return idx >= cnt;
    endfunction

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             trig_timer,
    input  logic             trig_ext,
    input  logic             pass_done,
    output logic             start_q,
    output logic             start_nxt,
    output logic [CNT_W-1:0] cnt_q,
    output logic             bank_nxt,
    output logic             flag_q,
    output logic             irq
);

    scan_cfg_t cfg_q, cfg_nxt;
    logic      flag_nxt;

    always_comb begin
        cfg_nxt   = wr_en ? decode_cfg(wr_data) : cfg_q;
        start_nxt = trig_timer | trig_ext | (wr_en ? wr_data[B_RUN] : start_q);
        flag_nxt  = flag_q;
        if (wr_en && !wr_data[B_KEEP]) flag_nxt = 1'b0;
        if (pass_done)                 flag_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            start_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            cfg_q   <= cfg_nxt;
            start_q <= start_nxt;
            flag_q  <= flag_nxt;
        end
    end

    assign cnt_q    = cfg_q.cnt;
    assign bank_nxt = cfg_nxt.bank;
    assign irq      = flag_q & cfg_q.ie;

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter  int NUM_CH     = 8,
    parameter  int GRP_OFFSET = 4,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_q,
    input  logic             start_nxt,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             bank_nxt,
    input  logic             conv_done,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_ch,
    output logic             res_we,
    output logic             pass_done
);

    seq_state_t       state_q;
    logic [CNT_W-1:0] idx_q, idx_nxt;
    logic [CH_W-1:0]  ch_q, base_nxt;
    logic             cs_q, rise, accept, last;

    always_comb begin
        rise     = start_nxt & ~start_q;
        accept   = (state_q == SEQ_WAIT) && conv_done && start_nxt;
        last     = idx_is_last(idx_q, cnt_q);
        idx_nxt  = (rise || last) ? '0 : idx_q + 1'b1;
        base_nxt = bank_nxt ? CH_W'(GRP_OFFSET) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            ch_q    <= '0;
            cs_q    <= 1'b0;
        end else begin
            cs_q <= 1'b0;
            if (!start_nxt) begin
                state_q <= SEQ_IDLE;
            end else if (rise || accept) begin
                state_q <= SEQ_WAIT;
                idx_q   <= idx_nxt;
                ch_q    <= base_nxt + CH_W'(idx_nxt);
                cs_q    <= 1'b1;
            end
        end
    end

    assign conv_start = cs_q;
    assign conv_ch    = ch_q;
    assign res_we     = accept;
    assign pass_done  = accept && last;

endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
    parameter  int NUM_CH = 8,
    parameter  int DATA_W = 10,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [CH_W-1:0]          ch,
    input  logic [DATA_W-1:0]        data,
    output logic [NUM_CH*DATA_W-1:0] res_flat
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)                          val_q <= '0;
            else if (we && ch == CH_W'(g))    val_q <= data;
        end
        assign res_flat[g*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter  int DATA_W     = 10,
    parameter  int NUM_CH     = 8,
    parameter  int GRP_OFFSET = 4,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CFG_W-1:0]         wr_data,
    input  logic                     trig_timer,
    input  logic                     trig_ext,
    output logic                     conv_start,
    output logic [CH_W-1:0]          conv_ch,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    output logic [NUM_CH*DATA_W-1:0] res_flat,
    output logic                     start_bit,
    output logic                     end_flag,
    output logic                     irq
);

    logic             start_nxt, bank_nxt, res_we, pass_done;
    logic [CNT_W-1:0] cnt_q;

    adc_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .trig_timer (trig_timer),
        .trig_ext   (trig_ext),
        .pass_done  (pass_done),
        .start_q    (start_bit),
        .start_nxt  (start_nxt),
        .cnt_q      (cnt_q),
        .bank_nxt   (bank_nxt),
        .flag_q     (end_flag),
        .irq        (irq)
    );

    adc_scan_fsm #(.NUM_CH(NUM_CH), .GRP_OFFSET(GRP_OFFSET)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_q    (start_bit),
        .start_nxt  (start_nxt),
        .cnt_q      (cnt_q),
        .bank_nxt   (bank_nxt),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .res_we     (res_we),
        .pass_done  (pass_done)
    );

    adc_scan_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_res (
        .clk      (clk),
        .rst      (rst),
        .we       (res_we),
        .ch       (conv_ch),
        .data     (conv_data),
        .res_flat (res_flat)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter  int DATA_W     = 10,
    parameter  int NUM_CH     = 8,
    parameter  int GRP_OFFSET = 4,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic                     wr_keep,
    input logic                     conv_start,
    input logic [CH_W-1:0]          conv_ch,
    input logic                     conv_done,
    input logic [NUM_CH*DATA_W-1:0] res_flat,
    input logic                     start_bit,
    input logic                     start_nxt,
    input logic                     end_flag,
    input logic                     irq
);

    p_rise_requests_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(start_bit) |-> conv_start);

    p_rise_at_base_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(start_bit) |-> (conv_ch == '0 || conv_ch == CH_W'(GRP_OFFSET)));

    p_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
        (start_bit && conv_done && start_nxt) |=> conv_start);

    p_pass_wraps_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(end_flag) |-> (conv_start && (conv_ch == '0 || conv_ch == CH_W'(GRP_OFFSET))));

    p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !start_bit |-> !conv_start);

    p_abort_discards_r7: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !start_nxt) |=> $stable(res_flat));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (end_flag && !(wr_en && !wr_keep)) |=> end_flag);

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> end_flag);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .GRP_OFFSET(GRP_OFFSET)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_keep    (wr_data[5]),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .conv_done  (conv_done),
    .res_flat   (res_flat),
    .start_bit  (start_bit),
    .start_nxt  (start_nxt),
    .end_flag   (end_flag),
    .irq        (irq)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

    localparam int DW  = 10;
    localparam int NCH = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [5:0]      wr_data = '0;
    logic            trig_timer = 1'b0, trig_ext = 1'b0;
    logic            conv_start;
    logic [2:0]      conv_ch;
    logic            conv_done = 1'b0;
    logic [DW-1:0]   conv_data = '0;
    logic [NCH*DW-1:0] res_flat;
    logic            start_bit, end_flag, irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    adc_scan_seq #(.DATA_W(DW), .NUM_CH(NCH), .GRP_OFFSET(4)) i_adc_scan_seq (
        .clk, .rst, .wr_en, .wr_data, .trig_timer, .trig_ext,
        .conv_start, .conv_ch, .conv_done, .conv_data, .res_flat,
        .start_bit, .end_flag, .irq
    );

    // reference model state
    logic            m_start, m_flag, m_ie, m_bank, m_busy, exp_cs;
    logic [1:0]      m_cnt, m_idx;
    logic [2:0]      exp_ch;
    logic [NCH*DW-1:0] exp_flat;
    logic            cv_busy;
    int              cv_cd, lat;
    logic [2:0]      cv_ch;
    bit              arm_abort, arm_fclr;

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, expv, $time);
        end
    endtask

    function automatic logic [2:0] ch_of(input logic bank, input logic [1:0] idx);
        return (bank ? 3'd4 : 3'd0) + {1'b0, idx};
    endfunction

    task automatic cycle();
        logic s_nx, rise, accept, last, f_nx, dn;
        logic [DW-1:0] dv;
        check(start_bit === m_start, "R1 start_bit", start_bit, m_start);
        check(end_flag === m_flag, "R6 R8 end_flag", end_flag, m_flag);
        check(irq === (m_flag & m_ie), "R9 irq", irq, m_flag & m_ie);
        check(conv_start === exp_cs, "R2 R4 R7 conv_start", conv_start, exp_cs);
        if (exp_cs) check(conv_ch === exp_ch, "R3 R6 R10 conv_ch", conv_ch, exp_ch);
        check(res_flat === exp_flat, "R5 R7 results", res_flat, exp_flat);
        // converter model
        dn = 1'b0; dv = '0;
        if (conv_start) begin
            cv_busy = 1'b1; cv_cd = lat; cv_ch = conv_ch;
        end else if (cv_busy) begin
            if (cv_cd == 0) begin
                dn = 1'b1; dv = DW'($urandom); cv_busy = 1'b0;
            end else cv_cd--;
        end
        if (arm_abort && dn) begin
            wr_en = 1'b1; wr_data = {1'b1, 1'b0, m_ie, m_bank, m_cnt}; arm_abort = 0;
        end
        if (arm_fclr && dn && m_idx >= m_cnt) begin
            wr_en = 1'b1; wr_data = {1'b0, 1'b1, m_ie, m_bank, m_cnt}; arm_fclr = 0;
        end
        conv_done = dn; conv_data = dv;
        // next state per requirements
        s_nx   = trig_timer | trig_ext | (wr_en ? wr_data[4] : m_start);
        rise   = s_nx & ~m_start;
        accept = m_busy & dn & s_nx;
        last   = m_idx >= m_cnt;
        f_nx   = m_flag;
        if (wr_en && !wr_data[5]) f_nx = 1'b0;
        if (accept && last) f_nx = 1'b1;
        if (accept) exp_flat[cv_ch*DW +: DW] = dv;
        if (wr_en) begin
            m_cnt = wr_data[1:0]; m_bank = wr_data[2]; m_ie = wr_data[3];
        end
        exp_cs = 1'b0;
        if (!s_nx) begin
            m_busy = 1'b0; cv_busy = 1'b0;
        end else if (rise) begin
            m_busy = 1'b1; m_idx = '0; exp_cs = 1'b1;
        end else if (accept) begin
            m_idx = last ? 2'd0 : m_idx + 2'd1; exp_cs = 1'b1;
        end
        if (exp_cs) exp_ch = ch_of(m_bank, m_idx);
        m_start = s_nx; m_flag = f_nx;
        @(negedge clk);
        wr_en = 1'b0; trig_timer = 1'b0; trig_ext = 1'b0; conv_done = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic write(input logic [5:0] d);
        wr_en = 1'b1; wr_data = d; cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_start = 0; m_flag = 0; m_ie = 0; m_bank = 0; m_busy = 0; exp_cs = 0;
        m_cnt = 0; m_idx = 0; exp_ch = 0; exp_flat = '0; cv_busy = 0; cv_cd = 0;
        cv_ch = 0; lat = 1; arm_abort = 0; arm_fclr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run(2);                                   // reset state
        // R2 R3 R4 R6: three channels, bank 0, irq enabled
        write(6'b111010);
        run(40);
        // R8: flag clear on the same edge as pass completion
        arm_fclr = 1; run(40);
        write({1'b0, 1'b1, 1'b1, 1'b0, 2'b10}); run(10);   // plain clear
        // R7: stop on a done cycle
        lat = 0; arm_abort = 1; run(20);
        // R1: timer trigger, bank 1, four channels
        write(6'b101111); run(3);
        trig_timer = 1'b1; run(30);
        write(6'b100111); run(3);
        // R1: external trigger beats a clearing write
        trig_ext = 1'b1; write(6'b100011); run(30);
        write(6'b100011); run(3);
        // R10: start with new config in the same write
        lat = 2; write(6'b110100); run(20);
        write(6'b110101); run(5);                // R8 keep bit
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 199);
            lat = $urandom_range(0, 3);
            if (r < 4) wr_data = {$urandom_range(0,1) == 1 ? 1'b1 : 1'b0,
                                  $urandom_range(0,3) != 0 ? 1'b1 : 1'b0,
                                  3'($urandom)};
            if (r < 4) wr_en = 1'b1;
            else if (r < 7) trig_timer = 1'b1;
            else if (r < 10) trig_ext = 1'b1;
            else if (r == 10) arm_abort = 1;
            else if (r == 11) arm_fclr = 1;
            cycle();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule